// File: doc/BRIEF.md
# Transmission-Character Decoder (10b to 8b) with Running-Disparity Tracking

This block turns 10-bit transmission characters of the DC-balanced 8b/10b line code back into a byte and a control flag. It tracks the running disparity from one character to the next. Every character is checked two ways: against the code table in both of its disparity forms, and against the disparity the stream currently holds. The code path has a register at the input and one at the output, so the result of a character always appears a fixed two clock edges after it is taken in.

Two decoders can share one stream when two characters arrive in the same cycle. The first decoder exposes the disparity that follows its character on a combinational chain output. The second decoder takes that value on its disparity input with the force input held high. The first decoder in turn is forced from the second decoder's registered disparity output. With an optional request, the idle control character can be removed from the stream of valid results while its disparity is still accounted for. Word alignment and comma search happen upstream of this block.

Top module: `tcode_decoder`

## Requirements
- R1: While reset is low, and after it is released, byte_out, ctrl_out, code_err, disp_err and valid_out are 0 and disp_out is 0 (0 means negative running disparity, 1 means positive).
- R2: A code taken in with en high at rising edge n gives its result, including valid_out high, for sampling at edge n+2. If en was low at edge n, then after edge n+1 valid_out, code_err and disp_err are 0, and byte_out, ctrl_out and disp_out keep their values.
- R3: code_in[9:4] is the 6-bit sub-block with bit a at code_in[9] and bit i at code_in[4]. code_in[3:0] is the 4-bit sub-block with bit f at code_in[3] and bit j at code_in[0]. For a legal data character, byte_out[4:0] is the 5-bit group and byte_out[7:5] is the 3-bit group, and ctrl_out is 0.
- R4: ctrl_out is 1 for exactly the twelve control characters, K28.0 to K28.7 and K23.7, K27.7, K29.7, K30.7, in either disparity form. For these, byte_out holds the matching byte value (for example 8'hBC for K28.5).
- R5: A code that matches no table entry in either disparity form, including an unknown sub-block or an illegal pairing of legal sub-blocks, sets code_err with byte_out = 0, ctrl_out = 0 and disp_err = 0.
- R6: A code that is legal only in the form for the opposite running disparity sets disp_err, keeps code_err at 0 and still decodes byte_out and ctrl_out.
- R7: disp_out is the running disparity after the decoded character. A 6-bit sub-block with more than three ones makes it positive and one with fewer makes it negative; a balanced sub-block leaves it unchanged; the 4-bit sub-block follows the same rule around two ones. On a disparity error the calculation restarts from the opposite of the current value; on a code error it proceeds from the current value.
- R8: While disp_force is high in the cycle after a character is taken in, disp_in replaces the stored running disparity as that character's starting disparity.
- R9: disp_chain shows, in the same cycle, the running disparity after the character held in the input register, or its starting disparity when no character is held; disp_out takes this value at the next edge.
- R10: If drop_idle is high when a legal K28.5 is taken in, and no error is flagged, that character gives valid_out = 0 with both error flags at 0, yet the running disparity still advances past it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | A character is present on code_in |
| code_in | input | 10 | Transmission character, bit a at bit 9 |
| drop_idle | input | 1 | Remove K28.5 idle characters from the valid stream |
| disp_in | input | 1 | Starting disparity used when forced |
| disp_force | input | 1 | Use disp_in instead of the stored disparity |
| byte_out | output | 8 | Decoded byte |
| ctrl_out | output | 1 | Decoded character is a control character |
| code_err | output | 1 | Character is not in the code table |
| disp_err | output | 1 | Character contradicts the running disparity |
| disp_out | output | 1 | Running disparity after the decoded character |
| disp_chain | output | 1 | Combinational disparity for a cascaded decoder |
| valid_out | output | 1 | Result outputs carry a new character |

## Verification
The assertions check on every cycle that valid results appear only two edges after an enable, that a code error is never combined with a disparity error or a non-zero byte, that both flags appear only with valid, that disparity and valid hold when no character is taken in, that disp_out takes the chain value, and that a dropped idle yields no valid. Which byte a code decodes to, which codes are illegal, and which disparity form is expected can only be shown by the bench. It encodes bytes with its own encoder, builds its own legality table for both disparity forms, and runs a disparity model through random streams, deliberate wrong-form characters, forced starting disparity and dropped idles.

// File: rtl/tcd_pkg.sv
package tcd_pkg;

  localparam int unsigned SUB6_W = 6;
  localparam int unsigned SUB4_W = 4;
  localparam int unsigned CODE_W = SUB6_W + SUB4_W;

  typedef struct packed {
    logic [2:0] y;
    logic [4:0] x;
    logic       k;
  } cand_t;

  // 6-bit sub-block for negative running disparity, abcdei with a as MSB
  function automatic logic [5:0] sub6_neg(input logic [4:0] x);
    logic [5:0] r;
    case (x)
      5'd0:  r = 6'b100111;  5'd1:  r = 6'b011101;  5'd2:  r = 6'b101101;
      5'd3:  r = 6'b110001;  5'd4:  r = 6'b110101;  5'd5:  r = 6'b101001;
      5'd6:  r = 6'b011001;  5'd7:  r = 6'b111000;  5'd8:  r = 6'b111001;
      5'd9:  r = 6'b100101;  5'd10: r = 6'b010101;  5'd11: r = 6'b110100;
      5'd12: r = 6'b001101;  5'd13: r = 6'b101100;  5'd14: r = 6'b011100;
      5'd15: r = 6'b010111;  5'd16: r = 6'b011011;  5'd17: r = 6'b100011;
      5'd18: r = 6'b010011;  5'd19: r = 6'b110010;  5'd20: r = 6'b001011;
      5'd21: r = 6'b101010;  5'd22: r = 6'b011010;  5'd23: r = 6'b111010;
      5'd24: r = 6'b110011;  5'd25: r = 6'b100110;  5'd26: r = 6'b010110;
      5'd27: r = 6'b110110;  5'd28: r = 6'b001110;  5'd29: r = 6'b101110;
      5'd30: r = 6'b011110;  default: r = 6'b101011;
    endcase
    return r;
  endfunction

  function automatic logic [5:0] enc6(input logic [4:0] x, input logic k, input logic rd);
    logic [5:0] b;
    b = (k && x == 5'd28) ? 6'b001111 : sub6_neg(x);
    if (rd) begin
      if ($countones(b) != 3)          b = ~b;
      else if (!k && x == 5'd7)        b = 6'b000111;
    end
    return b;
  endfunction

  function automatic logic disp6(input logic [5:0] c, input logic rd);
    if ($countones(c) > 3)      return 1'b1;
    else if ($countones(c) < 3) return 1'b0;
    return rd;
  endfunction

  function automatic logic disp4(input logic [3:0] c, input logic rd);
    if ($countones(c) > 2)      return 1'b1;
    else if ($countones(c) < 2) return 1'b0;
    return rd;
  endfunction

  function automatic logic [3:0] enc4(input logic [2:0] y, input logic [4:0] x,
                                      input logic k, input logic rd6);
    logic [3:0] b;
    logic       alt;
    alt = (y == 3'd7) && (k ||
          (!rd6 && (x == 5'd17 || x == 5'd18 || x == 5'd20)) ||
          ( rd6 && (x == 5'd11 || x == 5'd13 || x == 5'd14)));
    case (y)
      3'd0: b = 4'b1011;  3'd1: b = 4'b1001;  3'd2: b = 4'b0101;
      3'd3: b = 4'b1100;  3'd4: b = 4'b1101;  3'd5: b = 4'b1010;
      3'd6: b = 4'b0110;  default: b = alt ? 4'b0111 : 4'b1110;
    endcase
    if (rd6 && ($countones(b) != 2 || y == 3'd3)) b = ~b;
    if (k && x == 5'd28 && !rd6 && $countones(b) == 2 && y != 3'd3) b = ~b;
    return b;
  endfunction

  function automatic logic [9:0] encode10(input cand_t c, input logic rd);
    logic [5:0] s6;
    s6 = enc6(c.x, c.k, rd);
    return {s6, enc4(c.y, c.x, c.k, disp6(s6, rd))};
  endfunction

  function automatic logic [4:0] find6(input logic [5:0] c);
    logic [4:0] r;
    r = 5'd0;
    for (int i = 0; i < 32; i++) begin
      if (c == enc6(i[4:0], 1'b0, 1'b0) || c == enc6(i[4:0], 1'b0, 1'b1)) r = i[4:0];
    end
    return r;
  endfunction

  function automatic logic [2:0] find4(input logic [3:0] c);
    logic [2:0] r;
    case (c)
      4'b1011, 4'b0100: r = 3'd0;
      4'b1001:          r = 3'd1;
      4'b0101:          r = 3'd2;
      4'b1100, 4'b0011: r = 3'd3;
      4'b1101, 4'b0010: r = 3'd4;
      4'b1010:          r = 3'd5;
      4'b0110:          r = 3'd6;
      default:          r = 3'd7;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/tcd_subdecode.sv
module tcd_subdecode
  import tcd_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  output cand_t             cand
);
  logic [SUB6_W-1:0] c6;
  logic [SUB4_W-1:0] c4, c4_eff;
  logic              k28_pos, k28_any, alt7;

  assign c6      = code[CODE_W-1:SUB4_W];
  assign c4      = code[SUB4_W-1:0];
  assign k28_pos = (c6 == 6'b110000);
  assign k28_any = k28_pos || (c6 == 6'b001111);
  assign alt7    = (c4 == 4'b0111) || (c4 == 4'b1000);

  // the positive-form K28 carries its balanced 4-bit groups inverted
  assign c4_eff = (k28_pos && $countones(c4) == 2 && c4 != 4'b1100 && c4 != 4'b0011)
                  ? ~c4 : c4;

  always_comb begin
    cand.x = k28_any ? 5'd28 : find6(c6);
    cand.y = find4(c4_eff);
    cand.k = k28_any ||
             (alt7 && (cand.x == 5'd23 || cand.x == 5'd27 ||
                       cand.x == 5'd29 || cand.x == 5'd30));
  end
endmodule

// File: rtl/tcd_verify.sv
module tcd_verify
  import tcd_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  input  cand_t             cand,
  input  logic              rd_start,
  output logic              bad_code,
  output logic              bad_disp,
  output logic              rd_next
);
  logic fits_neg, fits_pos, rd_base;

  // re-encode the candidate in both forms: this covers every table and pairing rule
  assign fits_neg = (encode10(cand, 1'b0) == code);
  assign fits_pos = (encode10(cand, 1'b1) == code);
  assign bad_code = !(fits_neg || fits_pos);
  assign bad_disp = !bad_code && (rd_start ? !fits_pos : !fits_neg);
  assign rd_base  = bad_disp ? !rd_start : rd_start;
  assign rd_next  = disp4(code[SUB4_W-1:0], disp6(code[CODE_W-1:SUB4_W], rd_base));
endmodule

// File: rtl/tcode_decoder.sv
module tcode_decoder
  import tcd_pkg::*;
#(
  parameter logic       RESET_RD = 1'b0,
  parameter logic [4:0] IDLE_X   = 5'd28,
  parameter logic [2:0] IDLE_Y   = 3'd5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en,
  input  logic [9:0]  code_in,
  input  logic        drop_idle,
  input  logic        disp_in,
  input  logic        disp_force,
  output logic [7:0]  byte_out,
  output logic        ctrl_out,
  output logic        code_err,
  output logic        disp_err,
  output logic        disp_out,
  output logic        disp_chain,
  output logic        valid_out
);
  localparam logic [7:0] IDLE_BYTE = {IDLE_Y, IDLE_X};

  logic [CODE_W-1:0] code_q;
  logic              fire, drop_q;
  cand_t             cand;
  logic              bad_code, bad_disp, rd_next, rd_start, idle_hit;

  // input stage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      fire   <= 1'b0;
      drop_q <= 1'b0;
    end else begin
      code_q <= code_in;
      fire   <= en;
      drop_q <= drop_idle;
    end
  end

  assign rd_start = disp_force ? disp_in : disp_out;

  tcd_subdecode u_sub (.code(code_q), .cand(cand));

  tcd_verify u_ver (
    .code(code_q), .cand(cand), .rd_start(rd_start),
    .bad_code(bad_code), .bad_disp(bad_disp), .rd_next(rd_next)
  );

  assign idle_hit   = fire && drop_q && !bad_code && !bad_disp && cand.k &&
                      ({cand.y, cand.x} == IDLE_BYTE);
  assign disp_chain = fire ? rd_next : rd_start;

  // output stage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_out  <= '0;
      ctrl_out  <= 1'b0;
      code_err  <= 1'b0;
      disp_err  <= 1'b0;
      disp_out  <= RESET_RD;
      valid_out <= 1'b0;
    end else begin
      valid_out <= fire && !idle_hit;
      code_err  <= fire && bad_code;
      disp_err  <= fire && bad_disp;
      if (fire) begin
        byte_out <= bad_code ? 8'h00 : {cand.y, cand.x};
        ctrl_out <= !bad_code && cand.k;
        disp_out <= rd_next;
      end
    end
  end
endmodule

// File: rtl/tcd_checker.sv
module tcd_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       en,
  input logic       fire,
  input logic       idle_hit,
  input logic [7:0] byte_out,
  input logic       ctrl_out,
  input logic       code_err,
  input logic       disp_err,
  input logic       disp_out,
  input logic       disp_chain,
  input logic       valid_out
);
  p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    valid_out |-> $past(en, 2));

  p_fire_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !idle_hit) |=> valid_out);

  p_code_err_clean_r5: assert property (@(posedge clk) disable iff (!rst_n)
    code_err |-> (!disp_err && !ctrl_out && byte_out == 8'h00));

  p_flag_with_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (code_err || disp_err) |-> valid_out);

  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> ($stable(disp_out) && !valid_out && !code_err && !disp_err));

  p_chain_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (disp_out == $past(disp_chain)));

  p_idle_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    idle_hit |=> (!valid_out && !code_err && !disp_err));
endmodule

bind tcode_decoder tcd_checker u_tcd_checker (
  .clk(clk), .rst_n(rst_n), .en(en), .fire(fire), .idle_hit(idle_hit),
  .byte_out(byte_out), .ctrl_out(ctrl_out), .code_err(code_err),
  .disp_err(disp_err), .disp_out(disp_out), .disp_chain(disp_chain),
  .valid_out(valid_out)
);

// File: tb/test_tcode_decoder.sv
module test_tcode_decoder;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0, drop_idle = 1'b0, disp_in = 1'b0, disp_force = 1'b0;
  logic [9:0] code_in = '0;
  logic [7:0] byte_out;
  logic       ctrl_out, code_err, disp_err, disp_out, disp_chain, valid_out;

  int n_checks = 0, n_fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tcode_decoder i_tcode_decoder (
    .clk(clk), .rst_n(rst_n), .en(en), .code_in(code_in), .drop_idle(drop_idle),
    .disp_in(disp_in), .disp_force(disp_force), .byte_out(byte_out),
    .ctrl_out(ctrl_out), .code_err(code_err), .disp_err(disp_err),
    .disp_out(disp_out), .disp_chain(disp_chain), .valid_out(valid_out)
  );

  // bench encoder: byte + control flag + starting disparity -> 10-bit code
  function automatic logic [9:0] b_enc(input logic [7:0] v, input bit k, input bit rd);
    logic [4:0] x; logic [2:0] y; logic [5:0] s6; logic [3:0] s4; bit r; int n;
    x = v[4:0]; y = v[7:5];
    case (x)
      0: s6=6'b100111; 1: s6=6'b011101; 2: s6=6'b101101; 3: s6=6'b110001;
      4: s6=6'b110101; 5: s6=6'b101001; 6: s6=6'b011001; 7: s6=6'b111000;
      8: s6=6'b111001; 9: s6=6'b100101; 10: s6=6'b010101; 11: s6=6'b110100;
      12: s6=6'b001101; 13: s6=6'b101100; 14: s6=6'b011100; 15: s6=6'b010111;
      16: s6=6'b011011; 17: s6=6'b100011; 18: s6=6'b010011; 19: s6=6'b110010;
      20: s6=6'b001011; 21: s6=6'b101010; 22: s6=6'b011010; 23: s6=6'b111010;
      24: s6=6'b110011; 25: s6=6'b100110; 26: s6=6'b010110; 27: s6=6'b110110;
      28: s6=6'b001110; 29: s6=6'b101110; 30: s6=6'b011110; default: s6=6'b101011;
    endcase
    if (k && x == 28) s6 = 6'b001111;
    n = $countones(s6);
    if (rd && (n != 3 || x == 7)) s6 = ~s6;
    r = ($countones(s6) > 3) ? 1'b1 : ($countones(s6) < 3) ? 1'b0 : rd;
    case (y)
      0: s4=4'b1011; 1: s4=4'b1001; 2: s4=4'b0101; 3: s4=4'b1100;
      4: s4=4'b1101; 5: s4=4'b1010; 6: s4=4'b0110; default: s4=4'b1110;
    endcase
    if (y == 7 && (k || (!r && (x==17 || x==18 || x==20)) || (r && (x==11 || x==13 || x==14))))
      s4 = 4'b0111;
    if (r && ($countones(s4) != 2 || y == 3)) s4 = ~s4;
    if (k && x == 28 && !r && $countones(s4) == 2 && y != 3) s4 = ~s4;
    return {s6, s4};
  endfunction

  function automatic bit b_rd_after(input logic [9:0] c, input bit s);
    bit r;
    r = ($countones(c[9:4]) > 3) ? 1'b1 : ($countones(c[9:4]) < 3) ? 1'b0 : s;
    return ($countones(c[3:0]) > 2) ? 1'b1 : ($countones(c[3:0]) < 2) ? 1'b0 : r;
  endfunction

  // legality table built from the bench encoder
  bit         ok_n [1024];
  bit         ok_p [1024];
  logic [7:0] t_val[1024];
  bit         t_k  [1024];
  logic [7:0] k_list[12];

  task automatic mark(input logic [7:0] v, input bit k);
    logic [9:0] c;
    c = b_enc(v, k, 1'b0); ok_n[c] = 1; t_val[c] = v; t_k[c] = k;
    c = b_enc(v, k, 1'b1); ok_p[c] = 1; t_val[c] = v; t_k[c] = k;
  endtask

  typedef struct {
    bit e; logic [9:0] c; bit d; bit f; bit fi; string tag;
  } stim_t;
  typedef struct {
    bit live; bit v; logic [7:0] b; bit k; bit ce; bit de; bit rd; string tag;
  } exp_t;

  stim_t p1;
  exp_t  p2, pe;
  bit    m_rd = 0;
  logic [7:0] last_b = 0;
  bit    last_k = 0;
  bit    exp_chain;

  task automatic check_out(input exp_t x);
    n_checks++;
    if ({valid_out, byte_out, ctrl_out, code_err, disp_err, disp_out} !==
        {x.v, x.b, x.k, x.ce, x.de, x.rd}) begin
      n_fails++;
      $display("FAIL %s: got v=%0b byte=%h k=%0b ce=%0b de=%0b rd=%0b, expected v=%0b byte=%h k=%0b ce=%0b de=%0b rd=%0b",
               x.tag, valid_out, byte_out, ctrl_out, code_err, disp_err, disp_out,
               x.v, x.b, x.k, x.ce, x.de, x.rd);
    end
  endtask

  // one clock: check the character from two steps back, process the one in the input stage
  task automatic advance();
    bit s, legal;
    @(negedge clk);
    if (p2.live) check_out(p2);
    disp_force = p1.f;
    disp_in    = p1.fi;
    s = p1.f ? p1.fi : m_rd;
    pe.live = 1; pe.tag = p1.tag;
    if (!p1.e) begin
      pe.v = 0; pe.ce = 0; pe.de = 0; pe.b = last_b; pe.k = last_k; pe.rd = m_rd;
      exp_chain = s;
    end else begin
      legal = ok_n[p1.c] || ok_p[p1.c];
      pe.ce = !legal;
      pe.de = legal && (s ? !ok_p[p1.c] : !ok_n[p1.c]);
      pe.b  = legal ? t_val[p1.c] : 8'h00;
      pe.k  = legal && t_k[p1.c];
      pe.rd = b_rd_after(p1.c, pe.de ? !s : s);
      pe.v  = !(p1.d && !pe.ce && !pe.de && pe.k && pe.b == 8'hBC);
      m_rd = pe.rd; last_b = pe.b; last_k = pe.k;
      exp_chain = pe.rd;
    end
    p2 = pe;
    #1;
    n_checks++;
    if (disp_chain !== exp_chain) begin
      n_fails++;
      $display("FAIL R9 (%s): disp_chain got %0b expected %0b", p1.tag, disp_chain, exp_chain);
    end
  endtask

  task automatic put(input bit e, input logic [9:0] c, input bit d, input bit f,
                     input bit fi, input string tag);
    en = e; code_in = c; drop_idle = d;
    p1.e = e; p1.c = c; p1.d = d; p1.f = f; p1.fi = fi; p1.tag = tag;
  endtask

  // one legal character in the correct form for its starting disparity
  task automatic send(input logic [7:0] v, input bit k, input string tag);
    advance();
    put(1, b_enc(v, k, m_rd), 0, 0, 0, tag);
  endtask

  initial begin
    automatic int unsigned seed = 32'h5EED_0A17;
    automatic int unsigned r;
    k_list = '{8'h1C, 8'h3C, 8'h5C, 8'h7C, 8'h9C, 8'hBC, 8'hDC, 8'hFC,
               8'hF7, 8'hFB, 8'hFD, 8'hFE};
    for (int i = 0; i < 256; i++) mark(i[7:0], 0);
    foreach (k_list[i]) mark(k_list[i], 1);
    void'($urandom(seed));
    p1 = '{e:0, c:'0, d:0, f:0, fi:0, tag:"R1"};
    p2.live = 0;

    // R1: reset state
    repeat (3) @(negedge clk);
    n_checks++;
    if ({byte_out, ctrl_out, code_err, disp_err, disp_out, valid_out} !== 13'd0) begin
      n_fails++;
      $display("FAIL R1: outputs %h expected 0",
               {byte_out, ctrl_out, code_err, disp_err, disp_out, valid_out});
    end
    rst_n = 1'b1;
    advance(); put(0, 10'h000, 0, 0, 0, "R1");
    advance(); put(0, 10'h000, 0, 0, 0, "R1");

    // R3: data characters
    for (int i = 0; i < 40; i++) send(8'($urandom()), 0, "R3");
    send(8'hF1, 0, "R3"); send(8'hEB, 0, "R3"); send(8'h07, 0, "R3");
    // R4: every control character, twice so both forms appear
    for (int j = 0; j < 2; j++) foreach (k_list[i]) send(k_list[i], 1, "R4");

    // R5: codes outside the table and illegal pairings
    advance(); put(1, 10'b0000000000, 0, 0, 0, "R5");
    advance(); put(1, 10'b1111111111, 0, 0, 0, "R5");
    advance(); put(1, {6'b111111, 4'b0101}, 0, 0, 0, "R5");
    advance(); put(1, {6'b100111, 4'b0000}, 0, 0, 0, "R5");
    advance(); put(1, {6'b111010, 4'b0111}, 0, 0, 0, "R5");
    advance(); put(1, {6'b100111, 4'b1011}, 0, 0, 0, "R5");
    send(8'h00, 0, "R7");

    // R6: wrong-form characters, followed by correct-form ones
    for (int i = 0; i < 12; i++) begin
      advance(); put(1, b_enc(8'($urandom()), 0, !m_rd), 0, 0, 0, "R6");
      send(8'($urandom()), 0, "R7");
    end
    advance(); put(1, b_enc(8'hBC, 1, !m_rd), 0, 0, 0, "R6");

    // R2: gaps with en low
    advance(); put(0, 10'h3FF, 0, 0, 0, "R2");
    advance(); put(0, 10'h155, 1, 0, 0, "R2");
    send(8'h4A, 0, "R2");
    advance(); put(0, 10'h000, 0, 0, 0, "R2");
    send(8'hBC, 1, "R2");

    // R8: forced starting disparity in both directions
    for (int i = 0; i < 8; i++) begin
      automatic bit fi = i[0];
      advance(); put(1, b_enc(8'($urandom()), 0, fi), 0, 1, fi, "R8");
      advance(); put(1, b_enc(8'h3F, 0, !fi), 0, 1, fi, "R8");
    end
    advance(); put(0, 10'h000, 0, 1, 1, "R8");

    // R10: idle removal
    advance(); put(1, b_enc(8'hBC, 1, m_rd), 1, 0, 0, "R10");
    send(8'h15, 0, "R10");
    advance(); put(1, b_enc(8'hBC, 1, m_rd), 1, 0, 0, "R10");
    advance(); put(1, b_enc(8'hBC, 1, m_rd), 1, 0, 0, "R10");
    advance(); put(1, b_enc(8'h1C, 1, m_rd), 1, 0, 0, "R10");
    advance(); put(1, b_enc(8'h2A, 0, m_rd), 1, 0, 0, "R10");
    advance(); put(1, b_enc(8'hBC, 1, !m_rd), 1, 0, 0, "R10");

    // random mix
    for (int i = 0; i < 3000; i++) begin
      automatic bit fo, fv, dr;
      automatic logic [7:0] v;
      automatic bit kk;
      r  = $urandom_range(0, 99);
      fo = ($urandom_range(0, 9) == 0);
      fv = 1'($urandom());
      dr = ($urandom_range(0, 3) == 0);
      kk = ($urandom_range(0, 5) == 0);
      v  = kk ? k_list[$urandom_range(0, 11)] : 8'($urandom());
      advance();
      if (r < 65)      put(1, b_enc(v, kk, fo ? fv : m_rd), dr, fo, fv, "R3");
      else if (r < 77) put(1, 10'($urandom()), dr, fo, fv, "R5");
      else if (r < 89) put(1, b_enc(v, kk, fo ? !fv : !m_rd), dr, fo, fv, "R6");
      else if (r < 95) put(0, 10'($urandom()), dr, fo, fv, "R2");
      else             put(1, b_enc(8'hBC, 1, fo ? fv : m_rd), 1, fo, fv, "R10");
    end

    advance(); put(0, 10'h000, 0, 0, 0, "R2");
    advance(); put(0, 10'h000, 0, 0, 0, "R2");
    advance();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end
endmodule